// File: doc/BRIEF.md
# Capture Control and Interrupt Unit

This unit sits between a register bus and an image-capture front end. It turns single-cycle register writes into capture commands: start, stop and soft reset. Start takes effect at once in the system clock domain. Stop and soft reset must be carried out by logic clocked from the sensor's pixel clock. Each of them crosses into that domain through a toggle handshake, produces a one-cycle pulse there, and returns an acknowledge. That acknowledge sets a completion flag in the status word. If the sensor clock is not running, a stop or reset stays pending. Software is expected to give up on it after its own timeout.

Event pulses from the capture datapath and the DMA latch into the status word: start of frame, transfer done for each path, overflow for each path, CRC error and frame overrun. Reading the status word clears the latched events. A separate interrupt mask is changed through a write-1-to-set port and a write-1-to-clear port, and it is read back at its own address. The single interrupt line is high whenever a latched event has its mask bit set.

Word addresses: 0 command, 1 status (clears on read), 2 mask set, 3 mask clear, 4 mask readback. Command word bits: 0 start, 1 stop, 2 soft reset, 8 codec path on.

Top module: `capture_ctrl_irq`

## Requirements
- R1: After reset, the status and mask words read 0, and `irq`, `cap_en`, `codec_en`, `pix_stop` and `pix_soft_rst` are 0.
- R2: A command write with bit 0 set raises `cap_en`, and one with bit 8 set raises `codec_en`, both on the next clock. A command write of zero changes neither.
- R3: A command write with bit 1 set (stop) gives exactly one `pix_stop` pulse in the pixel clock domain. Once that completes, status bit 1 becomes 1 and `cap_en` and `codec_en` fall to 0.
- R4: A command write with bit 2 set (soft reset) gives exactly one `pix_soft_rst` pulse in the pixel clock domain. On completion, status bit 2 becomes 1, `cap_en` and `codec_en` fall to 0, and every mask bit is cleared except bit 2.
- R5: While the pixel clock is stopped, a stop command does not complete. It completes after the pixel clock starts running.
- R6: A stop or reset write that arrives while the same command is still pending is ignored. It produces no second pulse and no second completion.
- R7: A command write that has bit 1 or bit 2 set ignores bits 0 and 8 in the same word.
- R8: Event inputs latch into status bits: start of frame at bit 10, preview and codec transfer done at bits 16 and 17, preview and codec overflow at bits 24 and 25, CRC error at bit 26, frame overrun at bit 27. Each latched bit stays set until the status word is read.
- R9: A status read returns the latched events and then clears them. An event that arrives in the same cycle as the read stays latched for the next read.
- R10: The mask-set port sets the mask bits written as 1, and the mask-clear port clears them. Zero bits have no effect. Only event bit positions (1, 2, 10, 16, 17, 24 to 27) are held, and all other mask bits read as 0.
- R11: `irq` is 1 exactly when some latched event has its mask bit set.
- R12: Status bit 0 shows `cap_en` and status bit 8 shows `codec_en`. A status read does not clear them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | System domain reset, active low |
| pix_clk | input | 1 | Sensor pixel clock, may be stopped |
| pix_rst_n | input | 1 | Pixel domain reset, active low |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 3 | Word address |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, valid the cycle after `rd_en` |
| ev_vsync | input | 1 | Start-of-frame pulse |
| ev_prev_done | input | 1 | Preview transfer done pulse |
| ev_codec_done | input | 1 | Codec transfer done pulse |
| ev_prev_ovf | input | 1 | Preview overflow pulse |
| ev_codec_ovf | input | 1 | Codec overflow pulse |
| ev_crc_err | input | 1 | CRC error pulse |
| ev_frame_ovr | input | 1 | Frame overrun pulse |
| cap_en | output | 1 | Capture enabled |
| codec_en | output | 1 | Codec path enabled |
| pix_stop | output | 1 | Stop pulse, pixel clock domain |
| pix_soft_rst | output | 1 | Soft reset pulse, pixel clock domain |
| irq | output | 1 | Interrupt request |

## Verification
The bench stops the pixel clock and issues a stop command. A design that completed commands without the pixel handshake would drop `cap_en` while the clock is still dead. It sends the same stop twice in back-to-back cycles and counts pixel-side pulses and completions. A design that toggles on every write would produce two of each. It also fires an event in the same cycle as a status read; a design that lets the clear win would lose that event. A soft reset is issued with the mask fully set, and the bench then checks that the mask reads back as bit 2 alone. Clearing bit 2 as well would silence the reset-done interrupt, and clearing nothing would leave stale interrupts armed. A combined start and stop word is also sent. A design that obeyed the start bit would show `cap_en` high after that write.

// File: rtl/cci_pkg.sv
package cci_pkg;
    localparam int unsigned DATA_W  = 32;
    localparam int unsigned ADDR_W  = 3;
    localparam int unsigned NUM_CMD = 2;

    localparam int unsigned CMD_STOP = 0;
    localparam int unsigned CMD_SRST = 1;

    // command word / status bit positions
    localparam int unsigned B_EN    = 0;
    localparam int unsigned B_STOP  = 1;
    localparam int unsigned B_SRST  = 2;
    localparam int unsigned B_CODEC = 8;
    localparam int unsigned B_VSYNC = 10;
    localparam int unsigned B_PDONE = 16;
    localparam int unsigned B_CDONE = 17;
    localparam int unsigned B_POVF  = 24;
    localparam int unsigned B_COVF  = 25;
    localparam int unsigned B_CRC   = 26;
    localparam int unsigned B_OVR   = 27;

    localparam logic [DATA_W-1:0] EVT_BITS =
        (DATA_W'(1) << B_STOP)  | (DATA_W'(1) << B_SRST)  |
        (DATA_W'(1) << B_VSYNC) | (DATA_W'(1) << B_PDONE) |
        (DATA_W'(1) << B_CDONE) | (DATA_W'(1) << B_POVF)  |
        (DATA_W'(1) << B_COVF)  | (DATA_W'(1) << B_CRC)   |
        (DATA_W'(1) << B_OVR);

    typedef enum logic [ADDR_W-1:0] {
        A_CMD  = 3'd0,
        A_STAT = 3'd1,
        A_MSET = 3'd2,
        A_MCLR = 3'd3,
        A_MASK = 3'd4
    } reg_addr_e;
endpackage

// File: rtl/cci_cmd_xing.sv
module cci_cmd_xing #(
    parameter int unsigned SYNC_STAGES = 2   // must be 2 or more
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pix_clk,
    input  logic pix_rst_n,
    input  logic start_i,
    output logic done_o,
    output logic pix_pulse_o
);
    typedef struct packed {
        logic                   req;
        logic                   ack_seen;
        logic [SYNC_STAGES-1:0] ack_sync;
    } sys_st_t;

    typedef struct packed {
        logic                   req_seen;
        logic                   ack;
        logic                   pulse;
        logic [SYNC_STAGES-1:0] req_sync;
    } pix_st_t;

    sys_st_t s_d, s_q;
    pix_st_t p_d, p_q;
    logic    busy;
    logic    ack_now;
    logic    req_now;

    // system side: toggle request, watch synchronized acknowledge
    always_comb begin
        s_d          = s_q;
        ack_now      = s_q.ack_sync[SYNC_STAGES-1];
        busy         = s_q.req ^ s_q.ack_seen;
        s_d.ack_sync = {s_q.ack_sync[SYNC_STAGES-2:0], p_q.ack};
        s_d.ack_seen = ack_now;
        s_d.req      = s_q.req ^ (start_i & ~busy);
        done_o       = ack_now ^ s_q.ack_seen;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    // pixel side: detect toggle, pulse once, return acknowledge
    always_comb begin
        p_d          = p_q;
        req_now      = p_q.req_sync[SYNC_STAGES-1];
        p_d.req_sync = {p_q.req_sync[SYNC_STAGES-2:0], s_q.req};
        p_d.req_seen = req_now;
        p_d.pulse    = req_now ^ p_q.req_seen;
        p_d.ack      = req_now;
    end

    always_ff @(posedge pix_clk or negedge pix_rst_n) begin
        if (!pix_rst_n) p_q <= '0;
        else            p_q <= p_d;
    end

    assign pix_pulse_o = p_q.pulse;

    // R6
    // a start while the handshake is open must not flip the request again
    pending_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && (s_q.req != s_q.ack_seen)) |=> $stable(s_q.req));

    // R3
    // completion cannot be seen while no request is open
    done_needs_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (s_q.req != s_q.ack_seen));
endmodule

// File: rtl/cci_irq_regs.sv
module cci_irq_regs
    import cci_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] set_vec,
    input  logic              rd_clr,
    input  logic              mset_wr,
    input  logic              mclr_wr,
    input  logic              mask_rst,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] evt_o,
    output logic [DATA_W-1:0] mask_o,
    output logic              irq_o
);
    typedef struct packed {
        logic [DATA_W-1:0] evt;
        logic [DATA_W-1:0] mask;
    } st_t;

    localparam logic [DATA_W-1:0] KEEP_ON_SRST = DATA_W'(1) << B_SRST;

    st_t d, q;

    always_comb begin
        d     = q;
        d.evt = (rd_clr ? '0 : q.evt) | (set_vec & EVT_BITS);
        if (mset_wr) d.mask = q.mask | (wdata & EVT_BITS);
        if (mclr_wr) d.mask = q.mask & ~wdata;
        if (mask_rst) d.mask = d.mask & KEEP_ON_SRST;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign evt_o  = q.evt;
    assign mask_o = q.mask;
    assign irq_o  = |(q.evt & q.mask);

    // R8
    evt_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (set_vec != '0) |=> ((evt_o & $past(set_vec & EVT_BITS)) == $past(set_vec & EVT_BITS)));

    // R9
    read_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_clr && (set_vec == '0)) |=> (evt_o == '0));

    // R10
    mask_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mclr_wr |=> ((mask_o & $past(wdata)) == '0));

    // R11
    no_mask_no_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mask_o == '0) |-> !irq_o);
endmodule

// File: rtl/capture_ctrl_irq.sv
module capture_ctrl_irq
    import cci_pkg::*;
#(
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pix_clk,
    input  logic              pix_rst_n,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    input  logic              ev_vsync,
    input  logic              ev_prev_done,
    input  logic              ev_codec_done,
    input  logic              ev_prev_ovf,
    input  logic              ev_codec_ovf,
    input  logic              ev_crc_err,
    input  logic              ev_frame_ovr,
    output logic              cap_en,
    output logic              codec_en,
    output logic              pix_stop,
    output logic              pix_soft_rst,
    output logic              irq
);
    typedef struct packed {
        logic              en;
        logic              codec;
        logic [DATA_W-1:0] rdata;
    } st_t;

    st_t d, q;

    logic                cmd_wr;
    logic                has_cmd;
    logic [NUM_CMD-1:0]  cmd_start;
    logic [NUM_CMD-1:0]  cmd_done;
    logic [NUM_CMD-1:0]  cmd_pulse;
    logic [DATA_W-1:0]   set_vec;
    logic [DATA_W-1:0]   evt;
    logic [DATA_W-1:0]   mask;
    logic [DATA_W-1:0]   levels;
    logic                rd_clr;

    assign cmd_wr                = wr_en && (addr == A_CMD);
    assign cmd_start[CMD_STOP]   = cmd_wr && wdata[B_STOP];
    assign cmd_start[CMD_SRST]   = cmd_wr && wdata[B_SRST];
    assign has_cmd               = |cmd_start;
    assign rd_clr                = rd_en && (addr == A_STAT);

    for (genvar g = 0; g < NUM_CMD; g++) begin : g_cmd
        cci_cmd_xing #(.SYNC_STAGES(SYNC_STAGES)) i_xing (
            .clk        (clk),
            .rst_n      (rst_n),
            .pix_clk    (pix_clk),
            .pix_rst_n  (pix_rst_n),
            .start_i    (cmd_start[g]),
            .done_o     (cmd_done[g]),
            .pix_pulse_o(cmd_pulse[g])
        );
    end

    always_comb begin
        set_vec          = '0;
        set_vec[B_STOP]  = cmd_done[CMD_STOP];
        set_vec[B_SRST]  = cmd_done[CMD_SRST];
        set_vec[B_VSYNC] = ev_vsync;
        set_vec[B_PDONE] = ev_prev_done;
        set_vec[B_CDONE] = ev_codec_done;
        set_vec[B_POVF]  = ev_prev_ovf;
        set_vec[B_COVF]  = ev_codec_ovf;
        set_vec[B_CRC]   = ev_crc_err;
        set_vec[B_OVR]   = ev_frame_ovr;
    end

    cci_irq_regs i_irq (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_vec (set_vec),
        .rd_clr  (rd_clr),
        .mset_wr (wr_en && (addr == A_MSET)),
        .mclr_wr (wr_en && (addr == A_MCLR)),
        .mask_rst(cmd_done[CMD_SRST]),
        .wdata   (wdata),
        .evt_o   (evt),
        .mask_o  (mask),
        .irq_o   (irq)
    );

    always_comb begin
        d             = q;
        levels        = '0;
        levels[B_EN]    = q.en;
        levels[B_CODEC] = q.codec;
        if (cmd_wr && !has_cmd) begin
            if (wdata[B_EN])    d.en    = 1'b1;
            if (wdata[B_CODEC]) d.codec = 1'b1;
        end
        if (|cmd_done) begin
            d.en    = 1'b0;
            d.codec = 1'b0;
        end
        if (rd_en) begin
            case (addr)
                A_STAT:  d.rdata = evt | levels;
                A_MASK:  d.rdata = mask;
                default: d.rdata = '0;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign rdata        = q.rdata;
    assign cap_en       = q.en;
    assign codec_en     = q.codec;
    assign pix_stop     = cmd_pulse[CMD_STOP];
    assign pix_soft_rst = cmd_pulse[CMD_SRST];

    // R4
    srst_done_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_done[CMD_SRST] |=> (!cap_en && !codec_en && ((mask & ~(DATA_W'(1) << B_SRST)) == '0)));

    // R7
    cmd_masks_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_wr && (wdata[B_STOP] || wdata[B_SRST]) && !cap_en) |=> !cap_en);

    // R2
    en_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_wr && !has_cmd && wdata[B_EN] && !(|cmd_done)) |=> cap_en);
endmodule

// File: tb/test_capture_ctrl_irq.sv
`timescale 1ns/1ps
module test_capture_ctrl_irq;
    import cci_pkg::*;

    logic clk = 0, pix_clk = 0, rst_n = 0;
    logic pix_run = 1;
    logic wr_en = 0, rd_en = 0;
    logic [ADDR_W-1:0] addr = '0;
    logic [DATA_W-1:0] wdata = '0, rdata;
    logic ev_vsync = 0, ev_prev_done = 0, ev_codec_done = 0, ev_prev_ovf = 0;
    logic ev_codec_ovf = 0, ev_crc_err = 0, ev_frame_ovr = 0;
    logic cap_en, codec_en, pix_stop, pix_soft_rst, irq;

    int n_chk = 0, n_fail = 0, n_stop = 0, n_srst = 0;
    logic [31:0] exp_evt = 0, exp_mask = 0;
    logic exp_en = 0, exp_codec = 0;
    logic [31:0] exp_q[$];
    string tag_q[$];
    logic rd_pend = 0;

    always #4 clk = ~clk;
    always begin
        #18;
        if (pix_run) pix_clk = ~pix_clk;
    end

    capture_ctrl_irq i_capture_ctrl_irq (
        .clk(clk), .rst_n(rst_n), .pix_clk(pix_clk), .pix_rst_n(rst_n),
        .wr_en(wr_en), .rd_en(rd_en), .addr(addr), .wdata(wdata), .rdata(rdata),
        .ev_vsync(ev_vsync), .ev_prev_done(ev_prev_done), .ev_codec_done(ev_codec_done),
        .ev_prev_ovf(ev_prev_ovf), .ev_codec_ovf(ev_codec_ovf), .ev_crc_err(ev_crc_err),
        .ev_frame_ovr(ev_frame_ovr), .cap_en(cap_en), .codec_en(codec_en),
        .pix_stop(pix_stop), .pix_soft_rst(pix_soft_rst), .irq(irq));

    always @(negedge pix_clk) begin
        if (pix_stop) n_stop++;
        if (pix_soft_rst) n_srst++;
    end

    // monitor: compare read data against the scoreboard queue
    always @(negedge clk) begin
        if (rd_pend && exp_q.size() > 0) begin
            logic [31:0] e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            n_chk++;
            if (rdata !== e) begin
                n_fail++;
                $display("FAIL %s: rdata got %h expected %h", t, rdata, e);
            end
        end
        rd_pend = rd_en;
    end

    task automatic check(input string t, input logic [31:0] got, input logic [31:0] expv);
        @(negedge clk);
        n_chk++;
        if (got !== expv) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", t, got, expv);
        end
    endtask

    task automatic wr(input logic [ADDR_W-1:0] a, input logic [31:0] v);
        @(posedge clk); #1;
        wr_en = 1; addr = a; wdata = v;
        @(posedge clk); #1;
        wr_en = 0; wdata = '0;
    endtask

    function automatic logic [31:0] levels();
        return (32'(exp_en) << B_EN) | (32'(exp_codec) << B_CODEC);
    endfunction

    task automatic rd_stat(input string t);
        @(posedge clk); #1;
        rd_en = 1; addr = A_STAT;
        exp_q.push_back(exp_evt | levels()); tag_q.push_back(t);
        exp_evt = 0;
        @(posedge clk); #1;
        rd_en = 0;
    endtask

    task automatic rd_mask(input string t);
        @(posedge clk); #1;
        rd_en = 1; addr = A_MASK;
        exp_q.push_back(exp_mask); tag_q.push_back(t);
        @(posedge clk); #1;
        rd_en = 0;
    endtask

    task automatic pulse_evt(input int unsigned bitpos);
        @(posedge clk); #1;
        case (bitpos)
            B_VSYNC: ev_vsync = 1;
            B_PDONE: ev_prev_done = 1;
            B_CDONE: ev_codec_done = 1;
            B_POVF:  ev_prev_ovf = 1;
            B_COVF:  ev_codec_ovf = 1;
            B_CRC:   ev_crc_err = 1;
            default: ev_frame_ovr = 1;
        endcase
        exp_evt |= 32'(1) << bitpos;
        @(posedge clk); #1;
        {ev_vsync, ev_prev_done, ev_codec_done, ev_prev_ovf, ev_codec_ovf, ev_crc_err, ev_frame_ovr} = '0;
    endtask

    task automatic settle(input int n);
        repeat (n) @(posedge clk);
    endtask

    task automatic finish_run();
        settle(4);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin
        int s0;
        settle(3);
        #1 rst_n = 1;
        // R1 reset state
        check("R1 cap_en", 32'(cap_en), 0);
        check("R1 codec_en", 32'(codec_en), 0);
        check("R1 irq", 32'(irq), 0);
        check("R1 pix pulses", 32'(pix_stop | pix_soft_rst), 0);
        rd_stat("R1 status");
        rd_mask("R1 mask");

        // R2 start and codec bits, zero write
        wr(A_CMD, 32'h1); exp_en = 1;
        check("R2 cap_en", 32'(cap_en), 1);
        check("R2 codec_en stays", 32'(codec_en), 0);
        wr(A_CMD, 32'h100); exp_codec = 1;
        check("R2 codec_en", 32'(codec_en), 1);
        wr(A_CMD, 32'h0);
        check("R2 zero write", {30'd0, cap_en, codec_en}, 32'h3);
        // R12 levels in status
        rd_stat("R12 level bits");

        // R8 each event latches at its bit
        pulse_evt(B_VSYNC); pulse_evt(B_PDONE); pulse_evt(B_CDONE); pulse_evt(B_POVF);
        pulse_evt(B_COVF); pulse_evt(B_CRC); pulse_evt(B_OVR);
        settle(5);
        rd_stat("R8 all events");
        // R9 cleared by read, levels kept (R12)
        rd_stat("R9 cleared after read");
        // R9 event in same cycle as read survives
        @(posedge clk); #1;
        rd_en = 1; addr = A_STAT; ev_vsync = 1;
        exp_q.push_back(levels()); tag_q.push_back("R9 same-cycle read");
        @(posedge clk); #1;
        rd_en = 0; ev_vsync = 0;
        exp_evt = 32'(1) << B_VSYNC;
        rd_stat("R9 same-cycle event kept");

        // R10 mask set / clear
        wr(A_MSET, 32'hFFFF_FFFF); exp_mask = EVT_BITS;
        rd_mask("R10 mask set all");
        wr(A_MCLR, 32'(1) << B_PDONE); exp_mask &= ~(32'(1) << B_PDONE);
        rd_mask("R10 mask clear one");
        wr(A_MCLR, 32'h0);
        rd_mask("R10 zero clear ignored");

        // R11 irq follows status and mask
        check("R11 irq idle", 32'(irq), 0);
        pulse_evt(B_VSYNC);
        check("R11 irq on masked event", 32'(irq), 1);
        rd_stat("R11 status with vsync");
        check("R11 irq after read", 32'(irq), 0);
        wr(A_MCLR, 32'(1) << B_CRC); exp_mask &= ~(32'(1) << B_CRC);
        pulse_evt(B_CRC);
        check("R11 irq unmasked event", 32'(irq), 0);
        rd_stat("R11 crc latched");

        // R3 stop command
        s0 = n_stop;
        wr(A_CMD, 32'(1) << B_STOP);
        settle(60);
        exp_en = 0; exp_codec = 0; exp_evt |= 32'(1) << B_STOP;
        check("R3 cap_en off", {30'd0, cap_en, codec_en}, 0);
        check("R3 one pulse", 32'(n_stop - s0), 1);
        check("R3 irq on stop done", 32'(irq), 1);
        rd_stat("R3 stop done bit");

        // R7 command word ignores start/codec
        wr(A_CMD, (32'(1) << B_STOP) | 32'h101);
        check("R7 cap_en not set", {30'd0, cap_en, codec_en}, 0);
        settle(60);
        exp_evt |= 32'(1) << B_STOP;
        rd_stat("R7 status after combined word");

        // R6 back-to-back stop gives one completion
        s0 = n_stop;
        @(posedge clk); #1;
        wr_en = 1; addr = A_CMD; wdata = 32'(1) << B_STOP;
        @(posedge clk); #1;
        @(posedge clk); #1;
        wr_en = 0; wdata = 0;
        settle(60);
        check("R6 single pulse", 32'(n_stop - s0), 1);
        exp_evt |= 32'(1) << B_STOP;
        rd_stat("R6 first completion");
        settle(60);
        rd_stat("R6 no second completion");

        // R4 soft reset
        wr(A_CMD, 32'h101); exp_en = 1; exp_codec = 1;
        wr(A_MSET, 32'hFFFF_FFFF); exp_mask = EVT_BITS;
        s0 = n_srst;
        wr(A_CMD, 32'(1) << B_SRST);
        settle(60);
        exp_en = 0; exp_codec = 0; exp_mask = 32'(1) << B_SRST;
        exp_evt |= 32'(1) << B_SRST;
        check("R4 enables off", {30'd0, cap_en, codec_en}, 0);
        check("R4 one pulse", 32'(n_srst - s0), 1);
        check("R4 irq on reset done", 32'(irq), 1);
        rd_mask("R4 mask keeps bit 2 only");
        rd_stat("R4 reset done bit");

        // R5 no completion without pixel clock
        wr(A_CMD, 32'h1); exp_en = 1;
        pix_run = 0;
        settle(10);
        wr(A_CMD, 32'(1) << B_STOP);
        settle(120);
        check("R5 still enabled", 32'(cap_en), 1);
        rd_stat("R5 no completion yet");
        pix_run = 1;
        settle(60);
        exp_en = 0; exp_evt |= 32'(1) << B_STOP;
        check("R5 done after clock runs", 32'(cap_en), 0);
        rd_stat("R5 completion bit");

        settle(4);
        finish_run();
    end
endmodule